// File: doc/BRIEF.md
# Synchronous Burst Address Sequencer

This block is the address front end of a synchronous SRAM-style memory. On every rising clock edge it decides whether to take a fresh external address, step through the current burst, or hold. A fresh address, together with the chip-enable state, is taken when either of two active-low address-status strobes is low. One strobe serves the processor side and one serves the controller side. Between captures, an active-low advance input steps a small burst counter. The counter covers the low address bits only.

The burst ordering is chosen by a static, unregistered mode input. In linear order the low bits count up from the start value and wrap. In interleaved order they are the start value XORed with the step count. The block drives the memory array with the resulting internal address and a registered "selected" flag. That flag falls one cycle after a capture taken with any chip enable inactive, which lets several devices share one bus in depth expansion.

Top module: `burst_addr_seq`

## Requirements
- R1: A low `rst_n` at a rising edge clears `mem_addr` to 0 and `sel` to 0 after that edge.
- R2: With `ads_ctrl_n` low at a rising edge, `mem_addr` equals the sampled `addr_in` after that edge. This holds whatever the state of `ce_pipe_n`.
- R3: With `ads_proc_n` low and `ce_pipe_n` low at a rising edge, `mem_addr` equals the sampled `addr_in` after that edge.
- R4: With `ads_proc_n` low, `ce_pipe_n` high and `ads_ctrl_n` high, no capture takes place. Both `mem_addr` and `sel` keep their values when `adv_n` is high.
- R5: When both strobes are low, the controller-side rule applies. A capture happens even with `ce_pipe_n` high.
- R6: With no strobe active and `adv_n` low, the step count rises by one per edge modulo 4. A burst is 4 words, and only the 2 low bits of `mem_addr` change.
- R7: With `burst_linear` = 1, the low 2 bits of `mem_addr` equal (start + k) mod 4 at step k.
- R8: With `burst_linear` = 0, the low 2 bits of `mem_addr` equal start XOR k at step k.
- R9: With no strobe active and `adv_n` high, `mem_addr` and `sel` hold.
- R10: `burst_linear` is not registered. A change of it alters `mem_addr` without any clock edge.
- R11: After a capture, `sel` is 1 only if `ce_pipe_n` = 0, `ce_hi` = 1 and `ce_lo_n` = 0 were sampled with it. Otherwise `sel` is 0 from the next cycle on.
- R12: A capture in the middle of a burst restarts the step count at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| addr_in | input | ADDR_W (18) | External address |
| ads_proc_n | input | 1 | Processor-side address strobe, active low, gated by `ce_pipe_n` |
| ads_ctrl_n | input | 1 | Controller-side address strobe, active low, always honoured |
| ce_pipe_n | input | 1 | Pipelining chip enable, active low |
| ce_hi | input | 1 | Depth-expansion enable, active high |
| ce_lo_n | input | 1 | Depth-expansion enable, active low |
| adv_n | input | 1 | Burst advance, active low |
| burst_linear | input | 1 | Ordering: 1 linear, 0 interleaved (unregistered) |
| mem_addr | output | ADDR_W (18) | Internal address to the array |
| sel | output | 1 | Registered device-selected flag |

## Verification
A corrupt stored base shows up on `mem_addr` in the cycle after the capture. An error in the upper bits is exposed at once by the hold and advance checks, because those bits must never move without a capture. A wrong step count or ordering appears only in the low two bits, and only within the 4-word burst. The bench therefore walks complete bursts in both orders from start values whose linear and interleaved sequences differ. A wrong strobe gating or enable decode is visible on `sel` exactly one edge after the offending strobe.

// File: rtl/burst_seq_pkg.sv
// Package: burst_seq_pkg
// Shared types and ordering helpers for the burst address sequencer.
// Assumes burst lengths that are a power of two.
package burst_seq_pkg;

    // Burst ordering selected by the static mode pin
    typedef enum logic {
        ORD_INTERLEAVED = 1'b0,
        ORD_LINEAR      = 1'b1
    } burst_order_e;

    // Decoded chip-enable inputs, all in active-high form
    typedef struct packed {
        logic pipe;
        logic depth_hi;
        logic depth_lo;
    } ce_set_t;

    // True when all enables are active
    function automatic logic ce_all_active(input ce_set_t ce);
        return ce.pipe & ce.depth_hi & ce.depth_lo;
    endfunction

endpackage

// File: rtl/burst_strobe_decode.sv
// Module: burst_strobe_decode
// Decides, per cycle, whether an address capture happens and what the
// selected flag becomes. The controller strobe is always honoured and wins
// over the processor strobe. The processor strobe is honoured only while
// the pipelining enable is active. Purely combinational.
module burst_strobe_decode
    import burst_seq_pkg::*;
(
    input  logic ads_proc_n,
    input  logic ads_ctrl_n,
    input  logic ce_pipe_n,
    input  logic ce_hi,
    input  logic ce_lo_n,
    output logic load,
    output logic from_ctrl,
    output logic sel_next
);

    ce_set_t ce;
    logic    proc_ok;

    // Convert the enables to active-high form
    always_comb begin
        ce.pipe     = ~ce_pipe_n;
        ce.depth_hi = ce_hi;
        ce.depth_lo = ~ce_lo_n;
    end

    // Strobe arbitration: controller first, then the gated processor strobe
    always_comb begin
        proc_ok   = ~ads_proc_n & ce.pipe;
        from_ctrl = ~ads_ctrl_n;
        load      = from_ctrl | proc_ok;
        sel_next  = ce_all_active(ce);
    end

endmodule

// File: rtl/burst_step_ctr.sv
// Module: burst_step_ctr
// Step counter within a burst. It clears on a capture and wraps modulo
// 2**BB on an advance. Otherwise it holds. Synchronous active-low reset.
module burst_step_ctr #(
    parameter int BB = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          adv_n,
    output logic [BB-1:0] step
);

    // Step register: reset, restart on capture, advance or hold
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step <= '0;
        end else if (load) begin
            step <= '0;
        end else if (!adv_n) begin
            step <= step + 1'b1;
        end
    end

endmodule

// File: rtl/burst_capture_regs.sv
// Module: burst_capture_regs
// Holds the captured start address and the selected flag. Both update
// only on a capture. Synchronous active-low reset clears both.
module burst_capture_regs #(
    parameter int AW = 18
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] addr_in,
    input  logic          sel_next,
    output logic [AW-1:0] base,
    output logic          sel
);

    // Base address and selected flag registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base <= '0;
            sel  <= 1'b0;
        end else if (load) begin
            base <= addr_in;
            sel  <= sel_next;
        end
    end

endmodule

// File: rtl/burst_order_map.sv
// Module: burst_order_map
// Forms the internal address from the stored base and the step count in
// the selected ordering. The upper bits pass through unchanged. The
// ordering input is unregistered, so this path is combinational.
module burst_order_map
    import burst_seq_pkg::*;
#(
    parameter int AW = 18,
    parameter int BB = 2
) (
    input  logic [AW-1:0] base,
    input  logic [BB-1:0] step,
    input  burst_order_e  order,
    output logic [AW-1:0] addr
);

    generate
        if (BB == 0) begin : g_no_burst
            // Degenerate case: no burst bits
            assign addr = base;
        end else begin : g_burst
            logic [BB-1:0] lin_low;
            logic [BB-1:0] ilv_low;

            // Compute both orderings and select one
            always_comb begin
                lin_low = base[BB-1:0] + step;
                ilv_low = base[BB-1:0] ^ step;
                addr[BB-1:0] = (order == ORD_LINEAR) ? lin_low : ilv_low;
            end

            if (AW > BB) begin : g_upper
                assign addr[AW-1:BB] = base[AW-1:BB];
            end
        end
    endgenerate

endmodule

// File: rtl/burst_addr_seq.sv
// Module: burst_addr_seq (top)
// Address front end of a synchronous SRAM-style memory. It captures an
// address and the enable state on either strobe, then generates burst
// addresses. Assumes that all inputs other than burst_linear are
// synchronous to clk.
module burst_addr_seq
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W     = 18,
    parameter int BURST_BITS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              ads_proc_n,
    input  logic              ads_ctrl_n,
    input  logic              ce_pipe_n,
    input  logic              ce_hi,
    input  logic              ce_lo_n,
    input  logic              adv_n,
    input  logic              burst_linear,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              sel
);

    localparam int STEP_W = (BURST_BITS > 0) ? BURST_BITS : 1;

    logic              load;
    logic              from_ctrl;
    logic              sel_next;
    logic [ADDR_W-1:0] base;
    logic [STEP_W-1:0] step;
    burst_order_e      order;

    // Map the mode pin onto the ordering type
    always_comb order = burst_linear ? ORD_LINEAR : ORD_INTERLEAVED;

    burst_strobe_decode u_decode (
        .ads_proc_n (ads_proc_n),
        .ads_ctrl_n (ads_ctrl_n),
        .ce_pipe_n  (ce_pipe_n),
        .ce_hi      (ce_hi),
        .ce_lo_n    (ce_lo_n),
        .load       (load),
        .from_ctrl  (from_ctrl),
        .sel_next   (sel_next)
    );

    burst_step_ctr #(.BB(STEP_W)) u_step (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .adv_n (adv_n),
        .step  (step)
    );

    burst_capture_regs #(.AW(ADDR_W)) u_capture (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .addr_in  (addr_in),
        .sel_next (sel_next),
        .base     (base),
        .sel      (sel)
    );

    burst_order_map #(.AW(ADDR_W), .BB(BURST_BITS)) u_map (
        .base  (base),
        .step  (step[STEP_W-1:0]),
        .order (order),
        .addr  (mem_addr)
    );

    // from_ctrl is kept for arbitration visibility only
    logic unused_ok;
    always_comb unused_ok = from_ctrl;

endmodule

// File: rtl/burst_addr_seq_chk.sv
// Module: burst_addr_seq_chk
// Assertion checker, bound to burst_addr_seq. It observes the ports only.
module burst_addr_seq_chk #(
    parameter int AW = 18,
    parameter int BB = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] addr_in,
    input logic          ads_proc_n,
    input logic          ads_ctrl_n,
    input logic          ce_pipe_n,
    input logic          ce_hi,
    input logic          ce_lo_n,
    input logic          adv_n,
    input logic [AW-1:0] mem_addr,
    input logic          sel
);

    logic cap;
    logic en_all;
    always_comb begin
        cap    = !ads_ctrl_n || (!ads_proc_n && !ce_pipe_n);
        en_all = !ce_pipe_n && ce_hi && !ce_lo_n;
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (!sel && mem_addr == '0));

    // R2
    ctrl_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ads_ctrl_n |=> mem_addr == $past(addr_in));

    // R3
    proc_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ads_proc_n && !ce_pipe_n) |=> mem_addr == $past(addr_in));

    // R4
    proc_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ads_ctrl_n && !ads_proc_n && ce_pipe_n && adv_n)
        |=> ($stable(sel) && $stable(mem_addr[AW-1:BB])));

    // R11
    sel_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap |=> sel == $past(en_all));

    // R6
    adv_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cap && !adv_n) |=> ($stable(mem_addr[AW-1:BB]) && $stable(sel)));

    // R9
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cap && adv_n) |=> ($stable(mem_addr[AW-1:BB]) && $stable(sel)));

endmodule

bind burst_addr_seq burst_addr_seq_chk #(.AW(ADDR_W), .BB(BURST_BITS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr_in    (addr_in),
    .ads_proc_n (ads_proc_n),
    .ads_ctrl_n (ads_ctrl_n),
    .ce_pipe_n  (ce_pipe_n),
    .ce_hi      (ce_hi),
    .ce_lo_n    (ce_lo_n),
    .adv_n      (adv_n),
    .mem_addr   (mem_addr),
    .sel        (sel)
);

// File: tb/burst_addr_seq_bench.sv
module burst_addr_seq_bench;

    localparam int AW = 18;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr_in = '0;
    logic          ads_proc_n = 1'b1;
    logic          ads_ctrl_n = 1'b1;
    logic          ce_pipe_n = 1'b1;
    logic          ce_hi = 1'b0;
    logic          ce_lo_n = 1'b1;
    logic          adv_n = 1'b1;
    logic          burst_linear = 1'b1;
    logic [AW-1:0] mem_addr;
    logic          sel;

    int n_run = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    burst_addr_seq u_burst_addr_seq (
        .clk(clk), .rst_n(rst_n), .addr_in(addr_in),
        .ads_proc_n(ads_proc_n), .ads_ctrl_n(ads_ctrl_n),
        .ce_pipe_n(ce_pipe_n), .ce_hi(ce_hi), .ce_lo_n(ce_lo_n),
        .adv_n(adv_n), .burst_linear(burst_linear),
        .mem_addr(mem_addr), .sel(sel)
    );

    typedef struct packed {
        logic          cn;    // ads_ctrl_n
        logic          pn;    // ads_proc_n
        logic          pipe_n;
        logic          hi;
        logic          lo_n;
        logic          adv;   // adv_n
        logic          lin;
        logic [AW-1:0] a;
        logic [AW-1:0] ea;
        logic          es;
        logic [7:0]    req;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VT [NV] = '{
        '{1'b0,1'b1,1'b0,1'b1,1'b0,1'b1,1'b1,18'h12345,18'h12345,1'b1,8'd2},  // R2
        '{1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,1'b1,18'h00000,18'h12346,1'b1,8'd7},  // R7
        '{1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,1'b1,18'h00000,18'h12347,1'b1,8'd7},
        '{1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,1'b1,18'h00000,18'h12344,1'b1,8'd7},
        '{1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,1'b1,18'h00000,18'h12345,1'b1,8'd6},  // R6 wrap
        '{1'b1,1'b1,1'b0,1'b1,1'b0,1'b1,1'b1,18'h3FFFF,18'h12345,1'b1,8'd9},  // R9
        '{1'b1,1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,18'h0ABCE,18'h0ABCE,1'b1,8'd3},  // R3
        '{1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,18'h00000,18'h0ABCF,1'b1,8'd8},  // R8
        '{1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,18'h00000,18'h0ABCC,1'b1,8'd8},
        '{1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,18'h00000,18'h0ABCD,1'b1,8'd8},
        '{1'b1,1'b0,1'b1,1'b1,1'b0,1'b1,1'b0,18'h3FFFF,18'h0ABCD,1'b1,8'd4},  // R4
        '{1'b0,1'b0,1'b1,1'b1,1'b0,1'b1,1'b0,18'h00003,18'h00003,1'b0,8'd5},  // R5
        '{1'b0,1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,18'h20000,18'h20000,1'b0,8'd11}, // R11
        '{1'b0,1'b1,1'b0,1'b1,1'b1,1'b1,1'b0,18'h01000,18'h01000,1'b0,8'd11},
        '{1'b0,1'b1,1'b0,1'b1,1'b0,1'b1,1'b1,18'h00102,18'h00102,1'b1,8'd2},
        '{1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,1'b1,18'h00000,18'h00103,1'b1,8'd6},
        '{1'b0,1'b1,1'b0,1'b1,1'b0,1'b1,1'b1,18'h00102,18'h00102,1'b1,8'd12}, // R12
        '{1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,1'b1,18'h00000,18'h00103,1'b1,8'd12}
    };

    task automatic check(input int req, input logic [AW-1:0] ea, input logic es);
        n_run++;
        if (mem_addr !== ea || sel !== es) begin
            n_fail++;
            $display("FAIL R%0d: mem_addr=%h sel=%b expected mem_addr=%h sel=%b",
                     req, mem_addr, sel, ea, es);
        end
    endtask

    task automatic idle();
        ads_ctrl_n = 1'b1; ads_proc_n = 1'b1; adv_n = 1'b1;
    endtask

    initial begin : watchdog
        #400000;
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : stim
        repeat (3) @(posedge clk);
        #2;
        // R1: state after reset
        check(1, '0, 1'b0);
        @(negedge clk) rst_n = 1'b1;

        foreach (VT[i]) begin
            @(negedge clk);
            ads_ctrl_n = VT[i].cn;  ads_proc_n = VT[i].pn;
            ce_pipe_n = VT[i].pipe_n; ce_hi = VT[i].hi; ce_lo_n = VT[i].lo_n;
            adv_n = VT[i].adv; burst_linear = VT[i].lin; addr_in = VT[i].a;
            @(posedge clk);
            #2;
            check(int'(VT[i].req), VT[i].ea, VT[i].es);
        end

        // R10: mode change with no clock edge, start low bits 01, step 1
        @(negedge clk);
        ads_ctrl_n = 1'b0; ce_pipe_n = 1'b0; ce_hi = 1'b1; ce_lo_n = 1'b0;
        burst_linear = 1'b1; addr_in = 18'h00101; adv_n = 1'b1;
        @(negedge clk);
        ads_ctrl_n = 1'b1; adv_n = 1'b0;
        @(posedge clk);
        #1;
        adv_n = 1'b1;
        check(10, 18'h00102, 1'b1);
        #1;
        burst_linear = 1'b0;
        #1;
        check(10, 18'h00100, 1'b1);

        // R1: reset in mid-operation
        @(negedge clk);
        idle();
        rst_n = 1'b0;
        @(posedge clk);
        #2;
        check(1, '0, 1'b0);
        @(negedge clk) rst_n = 1'b1;
        @(posedge clk);
        #2;
        check(9, '0, 1'b0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule